// File: doc/BRIEF.md
# Nested Preemptive Priority Interrupt Controller

This block arbitrates among a parameterised set of hardware interrupt lines plus one software-raised request, and tells a processor-side sequencer when to start a handler, when that start interrupts a handler already running, and when a handler that is finishing can hand over straight to the next one without restoring and re-saving context. Every source has an 8-bit priority value. A lower value is more urgent. A programmable split point divides the value into a group part (upper bits) and a subpriority part (lower bits).

Only a strictly more urgent group can interrupt a running handler. The subpriority orders requests that are waiting. A stack of active group levels records the nesting. When a handler exits, the level it interrupted governs again. A priority threshold lets a running handler shut out requests, so that it cannot be preempted. The software request is meant to drive context switching and resets to the least urgent value. Saving and restoring registers is left to the processor side.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `take_o`, `chain_o` and `preempt_o` are low. Hardware priorities reset to 0x00, the software-request priority to 0xFF, the split to 3 and the threshold to 0.
- R2: A rising edge on `irq_i[i]` latches a pending request for vector i. An edge in the same cycle as an entry or a chained entry is kept and is not lost.
- R3: The group of a source is its priority shifted right by the split. The split is the low 3 bits written to address NSRC+1. Among eligible pending requests the lowest 8-bit priority value wins, and equal values go to the lowest vector.
- R4: With no handler active and an eligible request pending, `take_o` rises with `vec_o`. It stays high until `enter_ack_i`, which commits that vector as active and clears its pending bit. `take_o` is low in the cycle after the acknowledge.
- R5: While handlers are active, `take_o` rises only for a request whose group is strictly below the group on top of the stack. `preempt_o` is then high with it.
- R6: A request whose group is equal to or above the active group never raises `take_o`. It stays pending.
- R7: On `exit_i`, if a pending request is eligible against the level that remains, `chain_o` pulses for one cycle in the next cycle with that `vec_o`. The vector is entered without an acknowledge.
- R8: On exit the previous group level is restored. Later arbitration compares against it, and the stack depth never exceeds its capacity.
- R9: A nonzero threshold written to address NSRC+2 excludes every source whose priority is greater than or equal to it. Writing 0 turns the threshold off.
- R10: Any write to address NSRC+3 raises the software request, which is vector NSRC. Its priority is held at address NSRC. Priorities of vector i are at address i.
- R11: `take_o` and `chain_o` are never high together, and `preempt_o` is high only with `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NSRC | Hardware request lines, edge-latched |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | clog2(NSRC+4) | Register write address |
| wr_data_i | input | 8 | Register write data |
| enter_ack_i | input | 1 | Processor has entered the offered handler |
| exit_i | input | 1 | Processor is returning from the current handler |
| take_o | output | 1 | Offer of a handler entry |
| preempt_o | output | 1 | The offered entry interrupts an active handler |
| chain_o | output | 1 | One-cycle pulse: chained entry on exit |
| vec_o | output | clog2(NSRC+1) | Vector of the offered or chained entry |

## Verification
The hardest condition to reach is a request edge that lands in the very cycle its neighbour is being committed. The bench lines up an acknowledge and a new line edge on the same clock, then checks that the late request shows up as a chained entry when the first handler exits. Chaining into a level that was restored from deeper nesting also takes setup. The stimulus builds a two-deep stack, finishes the inner handler, and then shows that a request in the outer group waits until the outer handler exits.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W  = 8;
    localparam int SPLIT_W = 3;
    typedef logic [PRIO_W-1:0]  prio_t;
    typedef logic [SPLIT_W-1:0] split_t;

    function automatic prio_t grp_of(prio_t p, split_t s);
        return p >> s;
    endfunction
endpackage

// File: rtl/pic_pick.sv
module pic_pick
    import pic_pkg::*;
#(
    parameter int NS = 9,
    parameter int VW = 4
) (
    input  logic [NS-1:0]   pend_i,
    input  prio_t [NS-1:0]  prio_i,
    input  prio_t           thresh_i,
    output logic            found_o,
    output logic [VW-1:0]   win_o,
    output prio_t           prio_o
);
    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        prio_o  = '1;
        for (int i = 0; i < NS; i++) begin
            // strict compare keeps the lower index on a tie
            if (pend_i[i] && (thresh_i == '0 || prio_i[i] < thresh_i)
                && (!found_o || prio_i[i] < prio_o)) begin
                found_o = 1'b1;
                win_o   = VW'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
    parameter int DEPTH = 9,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [DW-1:0]              din_i,
    output logic [DW-1:0]              top_o,
    output logic [DW-1:0]              nxt_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        for (int i = 0; i < DEPTH; i++) begin
            // pop+push replaces the top entry; plain push writes above it
            if (push_i && ((pop_i && stk_q.cnt == CW'(i + 1)) ||
                           (!pop_i && stk_q.cnt == CW'(i))))
                stk_d.mem[i] = din_i;
        end
        if (push_i && !pop_i && stk_q.cnt < CW'(DEPTH))
            stk_d.cnt = stk_q.cnt + 1'b1;
        else if (pop_i && !push_i && stk_q.cnt != '0)
            stk_d.cnt = stk_q.cnt - 1'b1;

        top_o = '0;
        nxt_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (stk_q.cnt == CW'(i + 1)) top_o = stk_q.mem[i];
            if (stk_q.cnt == CW'(i + 2)) nxt_o = stk_q.mem[i];
        end
        cnt_o = stk_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            irq_i,
    input  logic                       wr_en_i,
    input  logic [$clog2(NSRC+4)-1:0]  wr_addr_i,
    input  logic [7:0]                 wr_data_i,
    input  logic                       enter_ack_i,
    input  logic                       exit_i,
    output logic                       take_o,
    output logic                       preempt_o,
    output logic                       chain_o,
    output logic [$clog2(NSRC+1)-1:0]  vec_o
);
    localparam int NS     = NSRC + 1;
    localparam int VW     = $clog2(NS);
    localparam int AW     = $clog2(NSRC + 4);
    localparam int CW     = $clog2(NS + 1);
    localparam int A_SPL  = NSRC + 1;
    localparam int A_THR  = NSRC + 2;
    localparam int A_SOFT = NSRC + 3;

    typedef struct packed {
        prio_t [NS-1:0]  prio;
        split_t          split;
        prio_t           thresh;
        logic [NS-1:0]   pend;
        logic [NSRC-1:0] irq;
        logic            take;
        logic            preempt;
        logic            chain;
        logic [VW-1:0]   vec;
    } st_t;

    st_t st_d, st_q;

    logic            found;
    logic [VW-1:0]   win;
    prio_t           win_prio;
    prio_t           top_grp, nxt_grp, push_grp;
    logic [CW-1:0]   stk_cnt;
    logic            push, pop;

    pic_pick #(.NS(NS), .VW(VW)) u_pick (
        .pend_i(st_q.pend), .prio_i(st_q.prio), .thresh_i(st_q.thresh),
        .found_o(found), .win_o(win), .prio_o(win_prio)
    );

    pic_stack #(.DEPTH(NS), .DW(PRIO_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .din_i(push_grp),
        .top_o(top_grp), .nxt_o(nxt_grp), .cnt_o(stk_cnt)
    );

    always_comb begin
        logic [NS-1:0] set_v, clr_v;
        logic          soft_set;
        logic          elig_now, elig_pop;
        prio_t         win_grp, ack_prio;

        st_d      = st_q;
        st_d.irq  = irq_i;
        st_d.take = 1'b0;
        st_d.preempt = 1'b0;
        st_d.chain   = 1'b0;
        soft_set  = 1'b0;
        clr_v     = '0;
        push      = 1'b0;
        pop       = 1'b0;

        if (wr_en_i) begin
            for (int i = 0; i < NS; i++)
                if (wr_addr_i == AW'(i)) st_d.prio[i] = wr_data_i;
            if (wr_addr_i == AW'(A_SPL))  st_d.split  = wr_data_i[SPLIT_W-1:0];
            if (wr_addr_i == AW'(A_THR))  st_d.thresh = wr_data_i;
            if (wr_addr_i == AW'(A_SOFT)) soft_set    = 1'b1;
        end
        set_v = {soft_set, irq_i & ~st_q.irq};

        win_grp  = grp_of(win_prio, st_q.split);
        ack_prio = '0;
        for (int i = 0; i < NS; i++)
            if (st_q.vec == VW'(i)) ack_prio = st_q.prio[i];
        elig_now = found && stk_cnt < CW'(NS) &&
                   (stk_cnt == '0 || win_grp < top_grp);
        elig_pop = found && (stk_cnt <= CW'(1) || win_grp < nxt_grp);
        push_grp = grp_of(ack_prio, st_q.split);

        if (exit_i && stk_cnt != '0) begin
            pop = 1'b1;
            if (elig_pop) begin
                push       = 1'b1;
                push_grp   = win_grp;
                st_d.chain = 1'b1;
                st_d.vec   = win;
                for (int i = 0; i < NS; i++)
                    if (win == VW'(i)) clr_v[i] = 1'b1;
            end
        end else if (enter_ack_i && st_q.take) begin
            push = 1'b1;
            for (int i = 0; i < NS; i++)
                if (st_q.vec == VW'(i)) clr_v[i] = 1'b1;
        end else if (elig_now) begin
            st_d.take    = 1'b1;
            st_d.vec     = win;
            st_d.preempt = (stk_cnt != '0);
        end

        st_d.pend = (st_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.prio[NS-1] <= '1;
            st_q.split     <= split_t'(3);
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o    = st_q.take;
    assign preempt_o = st_q.preempt;
    assign chain_o   = st_q.chain;
    assign vec_o     = st_q.vec;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int NS = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    take_o,
    input logic                    preempt_o,
    input logic                    chain_o,
    input logic                    enter_ack_i,
    input logic                    exit_i,
    input logic [$clog2(NS)-1:0]   vec_o,
    input logic [$clog2(NS+1)-1:0] stk_cnt
);
    // R11
    take_chain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_o && chain_o));
    // R11
    preempt_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> take_o);
    // R7
    chain_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_o) |-> $past(exit_i));
    // R4
    ack_drops_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && enter_ack_i && !exit_i) |=> !take_o);
    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= ($clog2(NS+1))'(NS));
    // R3
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o || chain_o) |-> int'(vec_o) < NS);
endmodule

bind pic_ctrl pic_chk #(.NS(NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_o(take_o), .preempt_o(preempt_o),
    .chain_o(chain_o), .enter_ack_i(enter_ack_i), .exit_i(exit_i),
    .vec_o(vec_o), .stk_cnt(stk_cnt)
);

// File: tb/tb_pic_ctrl.sv
module tb_pic_ctrl;
    localparam int NSRC = 8;
    localparam int AW = $clog2(NSRC + 4);
    localparam int VW = $clog2(NSRC + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NSRC-1:0] irq_i = '0;
    logic wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic enter_ack_i = 1'b0, exit_i = 1'b0;
    logic take_o, preempt_o, chain_o;
    logic [VW-1:0] vec_o;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct { bit is_chain; int vec; bit pre; string tag; } exp_t;
    exp_t expq[$];
    logic take_seen = 1'b0;

    pic_ctrl #(.NSRC(NSRC)) dut (.*);

    always #10 clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_take(int v, bit p, string tag);
        exp_t e; e.is_chain = 0; e.vec = v; e.pre = p; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic expect_chain(int v, string tag);
        exp_t e; e.is_chain = 1; e.vec = v; e.pre = 0; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic observe(bit is_chain, int v, bit p);
        exp_t e;
        if (expq.size() == 0) begin
            chk(0, is_chain ? "unexpected chain" : "unexpected take", v, -1);
        end else begin
            e = expq.pop_front();
            chk(e.is_chain == is_chain, {e.tag, " kind"}, int'(is_chain), int'(e.is_chain));
            chk(e.vec == v, {e.tag, " vector"}, v, e.vec);
            if (!is_chain) chk(e.pre == p, {e.tag, " preempt"}, int'(p), int'(e.pre));
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (chain_o) observe(1, int'(vec_o), 1'b0);
            if (take_o && !take_seen) observe(0, int'(vec_o), preempt_o);
            take_seen <= take_o;
        end else begin
            take_seen <= 1'b0;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = 8'(d);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic raise(logic [NSRC-1:0] m);
        @(negedge clk); irq_i = m;
        @(negedge clk);
        @(negedge clk); irq_i = '0;
    endtask

    task automatic ack();
        int n = 0;
        @(negedge clk);
        while (!take_o && n < 50) begin @(negedge clk); n++; end
        enter_ack_i = 1'b1;
        @(negedge clk);
        enter_ack_i = 1'b0;
    endtask

    task automatic leave();
        @(negedge clk); exit_i = 1'b1;
        @(negedge clk); exit_i = 1'b0;
        idle(2);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(take_o == 0, "R1 take", int'(take_o), 0);
        chk(chain_o == 0, "R1 chain", int'(chain_o), 0);
        chk(preempt_o == 0, "R1 preempt", int'(preempt_o), 0);

        // R1/R10: src0 (reset 0x00) beats software request (reset 0xFF)
        expect_take(0, 0, "R1");
        @(negedge clk);
        irq_i[0] = 1'b1; wr_en_i = 1'b1; wr_addr_i = AW'(NSRC + 3);
        @(negedge clk);
        wr_en_i = 1'b0; irq_i = '0;
        ack();
        idle(3);
        chk(take_o == 0, "R6 soft waits", int'(take_o), 0);
        expect_chain(NSRC, "R10");
        leave();
        leave();

        wr(1, 8'h21); wr(2, 8'h40); wr(3, 8'h45);
        wr(4, 8'h42); wr(5, 8'h20); wr(6, 8'h42);

        // R4 plain entry
        expect_take(2, 0, "R4");
        raise(8'h04);
        ack();
        chk(take_o == 0, "R4 drop after ack", int'(take_o), 0);
        // R5 preemption by group 4 over group 8
        expect_take(5, 1, "R5");
        raise(8'h20);
        ack();
        // R6 same group waits, R7 chain on exit
        raise(8'h02);
        idle(4);
        chk(take_o == 0, "R6 same group", int'(take_o), 0);
        expect_chain(1, "R7");
        leave();
        // R8 restored level 8 blocks group 8 request
        leave();
        raise(8'h10);
        idle(4);
        chk(take_o == 0, "R8 restored level", int'(take_o), 0);
        expect_chain(4, "R8");
        leave();
        leave();

        // R3 subpriority
        expect_take(4, 0, "R3 sub");
        raise(8'h18);
        ack();
        expect_chain(3, "R3 sub");
        leave();
        leave();
        // R3 tie goes to lower index
        expect_take(4, 0, "R3 tie");
        raise(8'h50);
        ack();
        expect_chain(6, "R3 tie");
        leave();
        leave();

        // R2 edge during entry is kept
        expect_take(5, 0, "R2");
        raise(8'h20);
        begin
            int n = 0;
            @(negedge clk);
            while (!take_o && n < 50) begin @(negedge clk); n++; end
            enter_ack_i = 1'b1; irq_i[1] = 1'b1;
            @(negedge clk);
            enter_ack_i = 1'b0;
            @(negedge clk);
            irq_i[1] = 1'b0;
        end
        idle(3);
        chk(take_o == 0, "R2 latched waits", int'(take_o), 0);
        expect_chain(1, "R2");
        leave();
        leave();

        // R3 split 0: full value is the group
        wr(NSRC + 1, 0);
        expect_take(3, 0, "R3 split");
        raise(8'h08);
        ack();
        expect_take(4, 1, "R3 split");
        raise(8'h10);
        ack();
        leave();
        leave();
        wr(NSRC + 1, 3);

        // R9 threshold
        wr(NSRC + 2, 8'h30);
        raise(8'h04);
        idle(4);
        chk(take_o == 0, "R9 masked", int'(take_o), 0);
        expect_take(5, 0, "R9 below threshold");
        raise(8'h20);
        ack();
        leave();
        chk(take_o == 0, "R9 masked after exit", int'(take_o), 0);
        expect_take(2, 0, "R9 unmask");
        wr(NSRC + 2, 0);
        ack();
        leave();

        idle(4);
        chk(expq.size() == 0, "R11 all events seen", expq.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule